// File: doc/BRIEF.md
# Vector Register File Write-Back Slot

This block sits between one vector functional unit that writes results (load, slide or mask) and the arbiter of a register-file bank. It holds one result beat at a time. A beat is an instruction tag, a register-file address, a data word and a byte-enable mask. While a beat is held, the block raises a write request toward the bank arbiter. When the arbiter takes the beat, the slot is freed in that same cycle, so the producer can hand over its next beat with no bubble.

The block returns two acknowledgements to the producer. The first, `wr_gnt_o`, is a flow-control grant: a beat is accepted in any cycle where `wr_valid_i` and `wr_gnt_o` are both high. The second, `commit_gnt_o`, is a one-cycle pulse. It is raised a fixed number of cycles after the arbiter took the beat, matching the write latency of the register file. Hazard logic should release a dependency only on this second acknowledgement, because only then is the data really stored. The latency is the parameter `COMMIT_LAT`, with a default of 1.

Top module: `vrf_wb_slot`

## Requirements
- R1: While reset is asserted, and right after it is released, `bank_req_o` is 0, `commit_gnt_o` is 0 and `wr_gnt_o` is 1.
- R2: When the slot is empty, `wr_gnt_o` is 1. A beat offered in that cycle appears on `bank_req_o`, `bank_id_o`, `bank_addr_o`, `bank_data_o` and `bank_be_o` after the next clock edge.
- R3: While `bank_req_o` is 1 and `bank_gnt_i` is 0, the request stays high and the tag, address, data and byte-enable do not change.
- R4: When `bank_req_o` and `bank_gnt_i` are both 1 and no new beat is offered, `bank_req_o` is 0 after the edge.
- R5: When the held beat is granted, `wr_gnt_o` is 1 in that same cycle. A beat offered in that cycle replaces the held one after the edge, and `bank_req_o` stays 1.
- R6: Every cycle with `bank_req_o` and `bank_gnt_i` both 1 produces exactly one cycle of `commit_gnt_o`, `COMMIT_LAT` cycles later (the next cycle at the default of 1). No other cycle has `commit_gnt_o` high.
- R7: `bank_gnt_i` while `bank_req_o` is 0 is ignored: no commit pulse follows and the slot stays empty.
- R8: A beat offered while `wr_gnt_o` is 0 is ignored, and the held contents remain unchanged.
- R9: Grants in consecutive cycles, with a new beat offered in each, give one beat per cycle and a commit pulse in each of the following cycles.
- R10: Reset (asynchronous, active low) clears a held beat and any commit pulse that is pending or showing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Producer offers a beat |
| wr_id_i | input | ID_W | Instruction tag of the offered beat |
| wr_addr_i | input | ADDR_W | Register-file address of the offered beat |
| wr_data_i | input | DATA_W | Data word of the offered beat |
| wr_be_i | input | DATA_W/8 | Byte-enable of the offered beat |
| wr_gnt_o | output | 1 | Flow-control grant: the slot can take a beat this cycle |
| bank_req_o | output | 1 | Write request toward the bank arbiter |
| bank_id_o | output | ID_W | Tag of the held beat |
| bank_addr_o | output | ADDR_W | Address of the held beat |
| bank_data_o | output | DATA_W | Data of the held beat |
| bank_be_o | output | DATA_W/8 | Byte-enable of the held beat |
| bank_gnt_i | input | 1 | Arbiter takes the held beat |
| commit_gnt_o | output | 1 | One-cycle pulse once the write has reached the register file |

## Verification
`wr_gnt_o` is combinational. The bench reads it one time unit after it changes the inputs, in the same cycle. The request and beat fields are registered, so they are due right after the edge that captures the offer or the grant. At the default latency, the commit pulse is due right after the edge that saw the grant and is gone one edge later. The bench drives inputs one time unit after each rising edge and samples the registered outputs at that same point, so every check falls exactly one edge after its cause. The reset check asserts reset in the middle of a cycle, when a commit pulse is visible, and reads the outputs before any further edge.

// File: rtl/vrf_wb_slot_pkg.sv
package vrf_wb_slot_pkg;

   localparam int unsigned WB_BITS_PER_BYTE = 8;

   // width of one flattened beat: tag, address, data and byte-enable
   function automatic int unsigned wb_beat_bits(input int unsigned id_w,
                                                input int unsigned addr_w,
                                                input int unsigned data_w);
      return id_w + addr_w + data_w + data_w / WB_BITS_PER_BYTE;
   endfunction

endpackage

// File: rtl/vrf_wb_slot_reg.sv
// One-entry valid/ready holding register; refills in the cycle it drains.
module vrf_wb_slot_reg #(
   parameter int unsigned BEAT_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              in_valid_i,
   input  logic [BEAT_W-1:0] in_beat_i,
   output logic              in_ready_o,
   output logic              out_valid_o,
   output logic [BEAT_W-1:0] out_beat_o,
   input  logic              out_take_i,
   output logic              drained_o
);

   logic              full_q;
   logic [BEAT_W-1:0] beat_q;
   logic              load;

   assign drained_o   = full_q & out_take_i;
   assign in_ready_o  = ~full_q | out_take_i;
   assign load        = in_valid_i & in_ready_o;
   assign out_valid_o = full_q;
   assign out_beat_o  = beat_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         full_q <= 1'b0;
      end else begin
         full_q <= load | (full_q & ~out_take_i);
      end
   end

   always_ff @(posedge clk_i) begin
      if (load) begin
         beat_q <= in_beat_i;
      end
   end

endmodule

// File: rtl/vrf_wb_commit_delay.sv
// Delays the drain pulse by the register-file write latency.
module vrf_wb_commit_delay #(
   parameter int unsigned LAT = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pulse_i,
   output logic pulse_o
);

   generate
      if (LAT == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               stage_q <= 1'b0;
            end else begin
               stage_q <= pulse_i;
            end
         end
         assign pulse_o = stage_q;
      end else begin : g_chain
         logic [LAT-1:0] chain_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               chain_q <= '0;
            end else begin
               chain_q <= {chain_q[LAT-2:0], pulse_i};
            end
         end
         assign pulse_o = chain_q[LAT-1];
      end
   endgenerate

endmodule

// File: rtl/vrf_wb_slot.sv
module vrf_wb_slot
   import vrf_wb_slot_pkg::*;
#(
   parameter int unsigned ID_W       = 3,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned COMMIT_LAT = 1,
   localparam int unsigned BE_W      = DATA_W / WB_BITS_PER_BYTE
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_valid_i,
   input  logic [ID_W-1:0]   wr_id_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [BE_W-1:0]   wr_be_i,
   output logic              wr_gnt_o,
   output logic              bank_req_o,
   output logic [ID_W-1:0]   bank_id_o,
   output logic [ADDR_W-1:0] bank_addr_o,
   output logic [DATA_W-1:0] bank_data_o,
   output logic [BE_W-1:0]   bank_be_o,
   input  logic              bank_gnt_i,
   output logic              commit_gnt_o
);

   localparam int unsigned BEAT_W = wb_beat_bits(ID_W, ADDR_W, DATA_W);

   generate
      if (DATA_W == 0 || (DATA_W % WB_BITS_PER_BYTE) != 0) begin : g_bad_data_w
         $error("vrf_wb_slot: DATA_W must be a non-zero multiple of 8");
      end
      if (ID_W == 0 || ADDR_W == 0) begin : g_bad_field_w
         $error("vrf_wb_slot: ID_W and ADDR_W must be non-zero");
      end
      if (COMMIT_LAT < 1) begin : g_bad_lat
         $error("vrf_wb_slot: COMMIT_LAT must be at least 1");
      end
   endgenerate

   logic [BEAT_W-1:0] beat_in;
   logic [BEAT_W-1:0] beat_held;
   logic              drained;

   assign beat_in = {wr_id_i, wr_addr_i, wr_data_i, wr_be_i};

   vrf_wb_slot_reg #(
      .BEAT_W (BEAT_W)
   ) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .in_valid_i  (wr_valid_i),
      .in_beat_i   (beat_in),
      .in_ready_o  (wr_gnt_o),
      .out_valid_o (bank_req_o),
      .out_beat_o  (beat_held),
      .out_take_i  (bank_gnt_i),
      .drained_o   (drained)
   );

   assign {bank_id_o, bank_addr_o, bank_data_o, bank_be_o} = beat_held;

   vrf_wb_commit_delay #(
      .LAT (COMMIT_LAT)
   ) u_commit (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pulse_i (drained),
      .pulse_o (commit_gnt_o)
   );

endmodule

// File: rtl/vrf_wb_slot_chk.sv
module vrf_wb_slot_chk #(
   parameter int unsigned ID_W       = 3,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned COMMIT_LAT = 1,
   localparam int unsigned BE_W      = DATA_W / 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_valid_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic [ID_W-1:0]   wr_id_i,
   input logic              wr_gnt_o,
   input logic              bank_req_o,
   input logic [ID_W-1:0]   bank_id_o,
   input logic [ADDR_W-1:0] bank_addr_o,
   input logic [DATA_W-1:0] bank_data_o,
   input logic [BE_W-1:0]   bank_be_o,
   input logic              bank_gnt_i,
   input logic              commit_gnt_o
);

   p_empty_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bank_req_o |-> wr_gnt_o);

   p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_valid_i && wr_gnt_o) |=> (bank_req_o && bank_data_o == $past(wr_data_i)
                                    && bank_id_o == $past(wr_id_i)));

   p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_req_o && !bank_gnt_i) |=> (bank_req_o && $stable(bank_id_o) && $stable(bank_addr_o)
                                       && $stable(bank_data_o) && $stable(bank_be_o)));

   p_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_req_o && !bank_gnt_i) |-> !wr_gnt_o);

   p_drain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_req_o && bank_gnt_i && !wr_valid_i) |=> !bank_req_o);

   p_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_req_o && bank_gnt_i) |-> wr_gnt_o);

   p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!bank_req_o && !wr_valid_i) |=> !bank_req_o);

   generate
      if (COMMIT_LAT == 1) begin : g_lat1
         p_commit_after_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (bank_req_o && bank_gnt_i) |=> commit_gnt_o);

         p_commit_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(bank_req_o && bank_gnt_i) |=> !commit_gnt_o);
      end
   endgenerate

endmodule

bind vrf_wb_slot vrf_wb_slot_chk #(
   .ID_W       (ID_W),
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .COMMIT_LAT (COMMIT_LAT)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .wr_valid_i   (wr_valid_i),
   .wr_data_i    (wr_data_i),
   .wr_id_i      (wr_id_i),
   .wr_gnt_o     (wr_gnt_o),
   .bank_req_o   (bank_req_o),
   .bank_id_o    (bank_id_o),
   .bank_addr_o  (bank_addr_o),
   .bank_data_o  (bank_data_o),
   .bank_be_o    (bank_be_o),
   .bank_gnt_i   (bank_gnt_i),
   .commit_gnt_o (commit_gnt_o)
);

// File: tb/vrf_wb_slot_tb.sv
`timescale 1ns/1ps
module vrf_wb_slot_tb;

   localparam int unsigned ID_W   = 3;
   localparam int unsigned ADDR_W = 8;
   localparam int unsigned DATA_W = 64;
   localparam int unsigned BE_W   = DATA_W / 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_valid = 1'b0;
   logic [ID_W-1:0]   wr_id = '0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [BE_W-1:0]   wr_be = '0;
   logic              wr_gnt;
   logic              bank_req;
   logic [ID_W-1:0]   bank_id;
   logic [ADDR_W-1:0] bank_addr;
   logic [DATA_W-1:0] bank_data;
   logic [BE_W-1:0]   bank_be;
   logic              bank_gnt = 1'b0;
   logic              commit_gnt;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   vrf_wb_slot #(
      .ID_W (ID_W), .ADDR_W (ADDR_W), .DATA_W (DATA_W), .COMMIT_LAT (1)
   ) u_dut (
      .clk_i (clk), .rst_ni (rst_n),
      .wr_valid_i (wr_valid), .wr_id_i (wr_id), .wr_addr_i (wr_addr),
      .wr_data_i (wr_data), .wr_be_i (wr_be), .wr_gnt_o (wr_gnt),
      .bank_req_o (bank_req), .bank_id_o (bank_id), .bank_addr_o (bank_addr),
      .bank_data_o (bank_data), .bank_be_o (bank_be),
      .bank_gnt_i (bank_gnt), .commit_gnt_o (commit_gnt)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic offer(input logic v, input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input logic [BE_W-1:0] be);
      wr_valid = v; wr_id = id; wr_addr = a; wr_data = d; wr_be = be;
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic check_beat(input string req, input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a,
                             input logic [DATA_W-1:0] d, input logic [BE_W-1:0] be);
      check({req, " req"},  {63'd0, bank_req}, 64'd1);
      check({req, " id"},   64'(bank_id), 64'(id));
      check({req, " addr"}, 64'(bank_addr), 64'(a));
      check({req, " data"}, bank_data, d);
      check({req, " be"},   64'(bank_be), 64'(be));
   endtask

   task automatic t_reset_r1;
      check("R1 req in reset", {63'd0, bank_req}, 64'd0);
      check("R1 commit in reset", {63'd0, commit_gnt}, 64'd0);
      rst_n = 1'b1;
      tick();
      check("R1 req after reset", {63'd0, bank_req}, 64'd0);
      check("R1 commit after reset", {63'd0, commit_gnt}, 64'd0);
      check("R1 ready after reset", {63'd0, wr_gnt}, 64'd1);
   endtask

   task automatic t_load_hold_r2_r3_r8;
      offer(1'b1, 3'd5, 8'h3C, 64'hDEAD_BEEF_0123_4567, 8'hA5);
      #1 check("R2 ready when empty", {63'd0, wr_gnt}, 64'd1);
      tick();
      offer(1'b1, 3'd2, 8'h11, 64'h1111_2222_3333_4444, 8'hFF);
      check_beat("R2 captured", 3'd5, 8'h3C, 64'hDEAD_BEEF_0123_4567, 8'hA5);
      #1 check("R8 not ready while held", {63'd0, wr_gnt}, 64'd0);
      for (int i = 0; i < 3; i++) begin
         tick();
         check_beat("R3 R8 held", 3'd5, 8'h3C, 64'hDEAD_BEEF_0123_4567, 8'hA5);
         check("R6 no commit while waiting", {63'd0, commit_gnt}, 64'd0);
      end
      offer(1'b0, '0, '0, '0, '0);
   endtask

   task automatic t_drain_r4_r6;
      bank_gnt = 1'b1;
      #1 check("R5 ready on grant", {63'd0, wr_gnt}, 64'd1);
      tick();
      bank_gnt = 1'b0;
      check("R4 req dropped", {63'd0, bank_req}, 64'd0);
      check("R6 commit pulse", {63'd0, commit_gnt}, 64'd1);
      tick();
      check("R6 pulse one cycle", {63'd0, commit_gnt}, 64'd0);
   endtask

   task automatic t_idle_grant_r7;
      bank_gnt = 1'b1;
      tick();
      bank_gnt = 1'b0;
      check("R7 stays empty", {63'd0, bank_req}, 64'd0);
      check("R7 no commit", {63'd0, commit_gnt}, 64'd0);
      tick();
      check("R7 no late commit", {63'd0, commit_gnt}, 64'd0);
   endtask

   task automatic t_stream_r5_r9;
      offer(1'b1, 3'd1, 8'h01, 64'hA1, 8'h01);
      tick();
      bank_gnt = 1'b1;
      for (int k = 2; k < 6; k++) begin
         offer(1'b1, 3'(k), 8'(k), 64'(k * 64'h1_0000_0001), 8'(k));
         tick();
         check_beat("R5 R9 replaced", 3'(k), 8'(k), 64'(k * 64'h1_0000_0001), 8'(k));
         check("R9 commit each cycle", {63'd0, commit_gnt}, 64'd1);
      end
      offer(1'b0, '0, '0, '0, '0);
      tick();
      bank_gnt = 1'b0;
      check("R4 drained after stream", {63'd0, bank_req}, 64'd0);
      check("R9 last commit", {63'd0, commit_gnt}, 64'd1);
      tick();
      check("R9 commits end", {63'd0, commit_gnt}, 64'd0);
   endtask

   task automatic t_reset_pending_r10;
      offer(1'b1, 3'd7, 8'hEE, 64'h77, 8'h0F);
      tick();
      offer(1'b1, 3'd6, 8'hDD, 64'h66, 8'hF0);
      bank_gnt = 1'b1;
      tick();
      bank_gnt = 1'b0;
      offer(1'b0, '0, '0, '0, '0);
      check("R10 pulse visible before reset", {63'd0, commit_gnt}, 64'd1);
      rst_n = 1'b0;
      #1;
      check("R10 commit cleared", {63'd0, commit_gnt}, 64'd0);
      check("R10 beat cleared", {63'd0, bank_req}, 64'd0);
      tick();
      rst_n = 1'b1;
      tick();
      check("R10 nothing after reset", {62'd0, bank_req, commit_gnt}, 64'd0);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset_r1();
      t_load_hold_r2_r3_r8();
      t_drain_r4_r6();
      t_idle_grant_r7();
      t_stream_r5_r9();
      t_reset_pending_r10();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule